// File: doc/BRIEF.md
# Load Issue Gate and Blocking Tracker

This block sits between load execution and the data cache port. Loads that found no matching store arrive here, up to `LANES` per cycle, lane 0 being the oldest in program order. For each one it decides in the same cycle whether to send a read to the cache, to hand the load back for rescheduling, or to report a fault. Two things stop a send. A load marked uncacheable may only go to memory when it sits at the load-queue head and is also at commit. Only `PORTS` cache ports may be used in one cycle.

When the cache is blocked, either at the start of the cycle or because an earlier lane's read was just refused, the affected loads are not sent. The tracker keeps the sequence number of the oldest such load, so the surrounding pipeline can later restart from it. A refusal marked as a bad address raises a fault instead of a retry. Any other refusal posts this unit's id as the retry requester. The pipeline clears the blocked record and sets its handled flag through two separate inputs.

Top module: `lig_gate`

## Requirements
- R1: A valid uncacheable load whose index differs from `head_idx`, or whose `ld_at_commit` bit is low, gets `resched` high and `send` low in the same cycle, and it uses no cache port.
- R2: An uncacheable load whose index equals `head_idx` and whose `ld_at_commit` bit is high is handled exactly like a cacheable load.
- R3: `ports_used` equals the number of lanes that reached the cache step this cycle and never exceeds `PORTS`. It is recomputed every cycle and is 0 in a cycle with no eligible load.
- R4: Ports go to eligible lanes in ascending lane order. An eligible lane that finds all ports used gets `resched` high and `send` low.
- R5: A lane that holds a port sends only when `cache_blocked` is low and no lower lane had a non-bad-address refusal in this cycle.
- R6: A sent load with `acc_ok` low and `bad_addr` high raises `fault` for that lane. It posts no retry and leaves the blocked record and later lanes untouched.
- R7: A sent load with `acc_ok` low and `bad_addr` low raises `retry_post` and drives `retry_unit` = `UNIT_ID`. It counts as blocked, and so do all later port-holding lanes in that cycle. `retry_unit` is 0 when `retry_post` is low.
- R8: Among the lanes blocked in a cycle, the one with the smallest sequence number is recorded on the next edge. `blk_valid` is set, `blk_seq` takes the new number and `blk_handled` is cleared. A candidate with a larger number than a still-valid record is ignored.
- R9: `blk_clr` clears `blk_valid` on the next edge, and `hdl_set` sets `blk_handled` on the next edge. A new record in the same cycle takes priority over both.
- R10: `resched_total` adds the number of lanes with `resched` high on every edge.
- R11: After reset, `blk_valid`, `blk_seq`, `blk_handled` and `resched_total` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | LANES | Load present on lane |
| ld_idx | input | LANES*QIDX_W | Load-queue index per lane |
| ld_seq | input | LANES*SEQ_W | Sequence number per lane |
| ld_at_commit | input | LANES | Load is at commit |
| ld_uncache | input | LANES | Load is uncacheable |
| head_idx | input | QIDX_W | Current load-queue head index |
| cache_blocked | input | 1 | Cache blocked at start of cycle |
| acc_ok | input | LANES | Cache accepted the read of that lane |
| bad_addr | input | LANES | Refusal reason is a bad address |
| blk_clr | input | 1 | Clear the blocked record |
| hdl_set | input | 1 | Mark the blocked record handled |
| send | output | LANES | Read sent to cache |
| resched | output | LANES | Load returned for rescheduling |
| fault | output | LANES | Machine-check fault for lane |
| retry_post | output | 1 | Retry requested from cache |
| retry_unit | output | UNIT_W | Id of requesting unit |
| ports_used | output | PCNT_W | Cache ports consumed this cycle |
| resched_total | output | CNT_W | Running count of rescheduled loads |
| blk_valid | output | 1 | Blocked record present |
| blk_seq | output | SEQ_W | Sequence number of oldest blocked load |
| blk_handled | output | 1 | Blocked record handled |

## Verification
The bench runs loads into the port limit with all three lanes busy. A design that reset its port count per lane, or that let a rejected uncacheable load take a port, would then send one read too many or starve a lower lane. A refusal on lane 0 must block the younger lanes in the same cycle. A design that sampled only the external blocked flag would send from lane 1, and one that recorded the first blocked lane instead of the oldest would hold the wrong sequence number. The bench also offers younger candidates against a valid record and combines a clear or handled input with a new record in the same cycle. A tracker that overwrote the record, or let the clear win, shows up in `blk_seq`, `blk_valid` or `blk_handled`. A long stretch of random traffic then covers the combinations of these cases.

// File: rtl/lig_pkg.sv
package lig_pkg;

    localparam int LIG_LANES   = 3;
    localparam int LIG_PORTS   = 2;
    localparam int LIG_QIDX_W  = 4;
    localparam int LIG_SEQ_W   = 16;
    localparam int LIG_CNT_W   = 16;
    localparam int LIG_UNIT_W  = 2;
    localparam int LIG_UNIT_ID = 1;

    // What the uncacheable filter decided for a lane
    typedef enum logic [1:0] {
        FATE_IDLE    = 2'd0,
        FATE_REFUSED = 2'd1,
        FATE_ELIG    = 2'd2
    } lane_fate_e;

    // Outcome of the port and cache step for a lane
    typedef struct packed {
        logic reached;   // took a cache port
        logic send;      // read issued
        logic denied;    // no port left
        logic fault;     // bad-address refusal
        logic retry;     // other refusal
        logic blk_hit;   // stopped by a blocked cache
    } lane_res_t;

    function automatic logic seq_before(input logic [63:0] a, input logic [63:0] b);
        return a < b;
    endfunction

endpackage

// File: rtl/lig_lane_filter.sv
module lig_lane_filter
    import lig_pkg::*;
#(
    parameter int QIDX_W = LIG_QIDX_W
) (
    input  logic              valid,
    input  logic [QIDX_W-1:0] idx,
    input  logic [QIDX_W-1:0] head,
    input  logic              at_commit,
    input  logic              uncache,
    output lane_fate_e        fate
);

    logic unc_ok;

    always_comb begin
        unc_ok = (idx == head) && at_commit;
        if (!valid)
            fate = FATE_IDLE;
        else if (uncache && !unc_ok)
            fate = FATE_REFUSED;
        else
            fate = FATE_ELIG;
    end

endmodule

// File: rtl/lig_port_arbiter.sv
module lig_port_arbiter
    import lig_pkg::*;
#(
    parameter int LANES  = LIG_LANES,
    parameter int PORTS  = LIG_PORTS,
    parameter int PCNT_W = $clog2(PORTS + 1)
) (
    input  lane_fate_e [LANES-1:0] fate,
    input  logic                   cache_blocked,
    input  logic [LANES-1:0]       acc_ok,
    input  logic [LANES-1:0]       bad_addr,
    output lane_res_t  [LANES-1:0] res,
    output logic [PCNT_W-1:0]      ports_used
);

    localparam logic [PCNT_W-1:0] PORT_LIM = PCNT_W'(PORTS);

    always_comb begin
        logic [PCNT_W-1:0] used;
        logic              chain_blk;
        used      = '0;
        chain_blk = cache_blocked;
        for (int i = 0; i < LANES; i++) begin
            res[i] = '0;
            if (fate[i] == FATE_ELIG) begin
                if (used >= PORT_LIM) begin
                    res[i].denied = 1'b1;
                end else begin
                    used           = used + PCNT_W'(1);
                    res[i].reached = 1'b1;
                    if (!chain_blk) begin
                        res[i].send = 1'b1;
                        if (!acc_ok[i]) begin
                            if (bad_addr[i]) begin
                                res[i].fault = 1'b1;
                            end else begin
                                res[i].retry = 1'b1;
                                chain_blk    = 1'b1;
                            end
                        end
                    end
                    if (chain_blk && !res[i].fault)
                        res[i].blk_hit = 1'b1;
                end
            end
        end
        ports_used = used;
    end

endmodule

// File: rtl/lig_block_tracker.sv
module lig_block_tracker
    import lig_pkg::*;
#(
    parameter int LANES = LIG_LANES,
    parameter int SEQ_W = LIG_SEQ_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES-1:0]       hit,
    input  logic [LANES*SEQ_W-1:0] seq_flat,
    input  logic                   clr,
    input  logic                   hdl_set,
    output logic                   valid_q,
    output logic [SEQ_W-1:0]       seq_q,
    output logic                   hdl_q
);

    logic             cand_v;
    logic [SEQ_W-1:0] cand;
    logic             keep_v;
    logic             take;

    always_comb begin
        cand_v = 1'b0;
        cand   = '0;
        for (int i = 0; i < LANES; i++) begin
            if (hit[i] && (!cand_v ||
                seq_before(64'(seq_flat[i*SEQ_W +: SEQ_W]), 64'(cand)))) begin
                cand_v = 1'b1;
                cand   = seq_flat[i*SEQ_W +: SEQ_W];
            end
        end
        keep_v = valid_q && !clr;
        take   = cand_v && !(keep_v && seq_before(64'(seq_q), 64'(cand)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            seq_q   <= '0;
            hdl_q   <= 1'b0;
        end else begin
            valid_q <= take | keep_v;
            if (take) begin
                seq_q <= cand;
                hdl_q <= 1'b0;
            end else if (hdl_set) begin
                hdl_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/lig_gate.sv
module lig_gate
    import lig_pkg::*;
#(
    parameter int LANES   = LIG_LANES,
    parameter int PORTS   = LIG_PORTS,
    parameter int QIDX_W  = LIG_QIDX_W,
    parameter int SEQ_W   = LIG_SEQ_W,
    parameter int CNT_W   = LIG_CNT_W,
    parameter int UNIT_W  = LIG_UNIT_W,
    parameter int UNIT_ID = LIG_UNIT_ID,
    parameter int PCNT_W  = $clog2(PORTS + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES-1:0]        ld_valid,
    input  logic [LANES*QIDX_W-1:0] ld_idx,
    input  logic [LANES*SEQ_W-1:0]  ld_seq,
    input  logic [LANES-1:0]        ld_at_commit,
    input  logic [LANES-1:0]        ld_uncache,
    input  logic [QIDX_W-1:0]       head_idx,
    input  logic                    cache_blocked,
    input  logic [LANES-1:0]        acc_ok,
    input  logic [LANES-1:0]        bad_addr,
    input  logic                    blk_clr,
    input  logic                    hdl_set,
    output logic [LANES-1:0]        send,
    output logic [LANES-1:0]        resched,
    output logic [LANES-1:0]        fault,
    output logic                    retry_post,
    output logic [UNIT_W-1:0]       retry_unit,
    output logic [PCNT_W-1:0]       ports_used,
    output logic [CNT_W-1:0]        resched_total,
    output logic                    blk_valid,
    output logic [SEQ_W-1:0]        blk_seq,
    output logic                    blk_handled
);

    lane_fate_e [LANES-1:0] fate;
    lane_res_t  [LANES-1:0] res;
    logic       [LANES-1:0] hit;
    logic       [LANES-1:0] retry_v;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lig_lane_filter #(.QIDX_W(QIDX_W)) u_filt (
            .valid     (ld_valid[g]),
            .idx       (ld_idx[g*QIDX_W +: QIDX_W]),
            .head      (head_idx),
            .at_commit (ld_at_commit[g]),
            .uncache   (ld_uncache[g]),
            .fate      (fate[g])
        );
        assign send[g]    = res[g].send;
        assign fault[g]   = res[g].fault;
        assign hit[g]     = res[g].blk_hit;
        assign retry_v[g] = res[g].retry;
        assign resched[g] = (fate[g] == FATE_REFUSED) || res[g].denied;
    end

    lig_port_arbiter #(.LANES(LANES), .PORTS(PORTS), .PCNT_W(PCNT_W)) u_arb (
        .fate          (fate),
        .cache_blocked (cache_blocked),
        .acc_ok        (acc_ok),
        .bad_addr      (bad_addr),
        .res           (res),
        .ports_used    (ports_used)
    );

    lig_block_tracker #(.LANES(LANES), .SEQ_W(SEQ_W)) u_trk (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .seq_flat (ld_seq),
        .clr      (blk_clr),
        .hdl_set  (hdl_set),
        .valid_q  (blk_valid),
        .seq_q    (blk_seq),
        .hdl_q    (blk_handled)
    );

    assign retry_post = |retry_v;
    assign retry_unit = retry_post ? UNIT_W'(UNIT_ID) : '0;

    always_ff @(posedge clk) begin
        if (rst)
            resched_total <= '0;
        else
            resched_total <= resched_total + CNT_W'($countones(resched));
    end

endmodule

// File: rtl/lig_gate_chk.sv
module lig_gate_chk #(
    parameter int LANES  = 3,
    parameter int PORTS  = 2,
    parameter int QIDX_W = 4,
    parameter int SEQ_W  = 16,
    parameter int CNT_W  = 16,
    parameter int PCNT_W = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic [LANES-1:0]        ld_valid,
    input logic [LANES*QIDX_W-1:0] ld_idx,
    input logic [LANES-1:0]        ld_at_commit,
    input logic [LANES-1:0]        ld_uncache,
    input logic [QIDX_W-1:0]       head_idx,
    input logic                    cache_blocked,
    input logic [LANES-1:0]        acc_ok,
    input logic [LANES-1:0]        bad_addr,
    input logic                    blk_clr,
    input logic [LANES-1:0]        send,
    input logic [LANES-1:0]        resched,
    input logic [LANES-1:0]        fault,
    input logic [PCNT_W-1:0]       ports_used,
    input logic [CNT_W-1:0]        resched_total,
    input logic                    blk_valid,
    input logic [SEQ_W-1:0]        blk_seq,
    input logic                    blk_handled
);

    a_r3_port_limit: assert property (@(posedge clk) disable iff (rst)
        ports_used <= PCNT_W'(PORTS));

    a_r5_blocked_no_send: assert property (@(posedge clk) disable iff (rst)
        cache_blocked |-> (send == '0));

    a_r8_new_record_unhandled: assert property (@(posedge clk) disable iff (rst)
        $rose(blk_valid) |-> !blk_handled);

    a_r8_record_never_younger: assert property (@(posedge clk) disable iff (rst)
        (blk_valid && $past(blk_valid) && !$past(blk_clr)) |-> (blk_seq <= $past(blk_seq)));

    a_r10_total_still: assert property (@(posedge clk) disable iff (rst)
        ($past(resched) == '0) |-> $stable(resched_total));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        a_r1_unc_refused: assert property (@(posedge clk) disable iff (rst)
            (ld_valid[g] && ld_uncache[g] &&
             ((ld_idx[g*QIDX_W +: QIDX_W] != head_idx) || !ld_at_commit[g]))
            |-> (resched[g] && !send[g]));

        a_r6_fault_cause: assert property (@(posedge clk) disable iff (rst)
            fault[g] |-> (send[g] && !acc_ok[g] && bad_addr[g]));
    end

endmodule

bind lig_gate lig_gate_chk #(
    .LANES(LANES), .PORTS(PORTS), .QIDX_W(QIDX_W),
    .SEQ_W(SEQ_W), .CNT_W(CNT_W), .PCNT_W(PCNT_W)
) u_chk (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_idx(ld_idx),
    .ld_at_commit(ld_at_commit), .ld_uncache(ld_uncache), .head_idx(head_idx),
    .cache_blocked(cache_blocked), .acc_ok(acc_ok), .bad_addr(bad_addr),
    .blk_clr(blk_clr), .send(send), .resched(resched), .fault(fault),
    .ports_used(ports_used), .resched_total(resched_total),
    .blk_valid(blk_valid), .blk_seq(blk_seq), .blk_handled(blk_handled)
);

// File: tb/lig_gate_bench.sv
`timescale 1ns/1ps
module lig_gate_bench;

    localparam int N = 3;
    localparam int P = 2;
    localparam int QW = 4;
    localparam int SW = 16;
    localparam int CW = 16;
    localparam int UW = 2;
    localparam int UID = 1;
    localparam int PW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [N-1:0]    ld_valid, ld_at_commit, ld_uncache, acc_ok, bad_addr;
    logic [N*QW-1:0] ld_idx;
    logic [N*SW-1:0] ld_seq;
    logic [QW-1:0]   head_idx;
    logic            cache_blocked, blk_clr, hdl_set;
    logic [N-1:0]    send, resched, fault;
    logic            retry_post, blk_valid, blk_handled;
    logic [UW-1:0]   retry_unit;
    logic [PW-1:0]   ports_used;
    logic [CW-1:0]   resched_total;
    logic [SW-1:0]   blk_seq;

    lig_gate u_lig_gate (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_seq(ld_seq),
        .ld_at_commit(ld_at_commit), .ld_uncache(ld_uncache), .head_idx(head_idx),
        .cache_blocked(cache_blocked), .acc_ok(acc_ok), .bad_addr(bad_addr),
        .blk_clr(blk_clr), .hdl_set(hdl_set), .send(send), .resched(resched),
        .fault(fault), .retry_post(retry_post), .retry_unit(retry_unit),
        .ports_used(ports_used), .resched_total(resched_total),
        .blk_valid(blk_valid), .blk_seq(blk_seq), .blk_handled(blk_handled)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // stimulus per lane
    bit v[N], unc[N], atc[N], ok[N], bad[N];
    int idx[N], sq[N];
    int head = 5;
    bit cb, clr, hs;

    // reference state
    bit m_valid, m_hdl;
    int m_seq, m_total;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic lane(int i, bit vv, int ix, int s, bit at, bit u, bit a, bit b);
        v[i] = vv; idx[i] = ix; sq[i] = s; atc[i] = at; unc[i] = u; ok[i] = a; bad[i] = b;
    endtask

    task automatic idle_lanes();
        for (int i = 0; i < N; i++) lane(i, 0, 0, 0, 0, 0, 1, 0);
        cb = 0; clr = 0; hs = 0;
    endtask

    task automatic go();
        bit e_send[N], e_res[N], e_flt[N];
        bit e_retry, blocked, hit_any;
        int used, best, resc;
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            ld_valid[i] = v[i]; ld_at_commit[i] = atc[i]; ld_uncache[i] = unc[i];
            acc_ok[i] = ok[i]; bad_addr[i] = bad[i];
            ld_idx[i*QW +: QW] = QW'(idx[i]); ld_seq[i*SW +: SW] = SW'(sq[i]);
        end
        head_idx = QW'(head); cache_blocked = cb; blk_clr = clr; hdl_set = hs;
        #1;
        // reference: walk the loads oldest first
        used = 0; blocked = cb; e_retry = 0; hit_any = 0; best = 0; resc = 0;
        for (int i = 0; i < N; i++) begin
            e_send[i] = 0; e_res[i] = 0; e_flt[i] = 0;
            if (!v[i]) continue;
            if (unc[i] && (idx[i] != head || !atc[i])) begin e_res[i] = 1; resc++; continue; end
            if (used >= P) begin e_res[i] = 1; resc++; continue; end
            used++;
            if (!blocked) begin
                e_send[i] = 1;
                if (!ok[i]) begin
                    if (bad[i]) begin e_flt[i] = 1; continue; end
                    e_retry = 1; blocked = 1;
                end
            end
            if (blocked) begin
                if (!hit_any || sq[i] < best) best = sq[i];
                hit_any = 1;
            end
        end
        for (int i = 0; i < N; i++) begin
            chk($sformatf("R5 send lane%0d", i), int'(send[i]), int'(e_send[i]));
            chk($sformatf("R4 resched lane%0d", i), int'(resched[i]), int'(e_res[i]));
            chk($sformatf("R6 fault lane%0d", i), int'(fault[i]), int'(e_flt[i]));
        end
        chk("R7 retry_post", int'(retry_post), int'(e_retry));
        chk("R7 retry_unit", int'(retry_unit), e_retry ? UID : 0);
        chk("R3 ports_used", int'(ports_used), used);
        chk("R10 resched_total", int'(resched_total), m_total);
        chk("R8 blk_valid", int'(blk_valid), int'(m_valid));
        chk("R8 blk_seq", int'(blk_seq), m_seq);
        chk("R9 blk_handled", int'(blk_handled), int'(m_hdl));
        // state after the coming edge
        m_total = (m_total + resc) % 65536;
        if (clr) m_valid = 0;
        if (hit_any && !(m_valid && m_seq < best)) begin
            m_valid = 1; m_seq = best; m_hdl = 0;
        end else if (hs) begin
            m_hdl = 1;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle_lanes();
        ld_valid = '0; ld_at_commit = '0; ld_uncache = '0; acc_ok = '1; bad_addr = '0;
        ld_idx = '0; ld_seq = '0; head_idx = '0; cache_blocked = 0; blk_clr = 0; hdl_set = 0;
        m_valid = 0; m_hdl = 0; m_seq = 0; m_total = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R11: reset state seen through the outputs
        chk("R11 blk_valid", int'(blk_valid), 0);
        chk("R11 blk_seq", int'(blk_seq), 0);
        chk("R11 blk_handled", int'(blk_handled), 0);
        chk("R11 resched_total", int'(resched_total), 0);
        // R3 idle cycle
        idle_lanes(); go();
        // single cacheable load
        lane(0, 1, 2, 100, 0, 0, 1, 0); go();
        // R4 three loads, two ports
        idle_lanes();
        lane(0, 1, 1, 10, 0, 0, 1, 0); lane(1, 1, 2, 11, 0, 0, 1, 0); lane(2, 1, 3, 12, 0, 0, 1, 0); go();
        // R1 and R2 uncacheable cases
        idle_lanes();
        lane(0, 1, 5, 20, 1, 1, 1, 0); lane(1, 1, 6, 21, 1, 1, 1, 0); lane(2, 1, 5, 22, 0, 1, 1, 0); go();
        // R1 refused lane leaves port for the next load
        idle_lanes();
        lane(0, 1, 7, 23, 0, 1, 1, 0); lane(1, 1, 1, 24, 0, 0, 1, 0); lane(2, 1, 2, 25, 0, 0, 1, 0); go();
        // R6 bad-address refusal then a good send
        idle_lanes();
        lane(0, 1, 1, 30, 0, 0, 0, 1); lane(1, 1, 2, 31, 0, 0, 1, 0); go();
        // R7 refusal blocks the younger lane, oldest recorded (R8)
        idle_lanes();
        lane(0, 1, 1, 40, 0, 0, 0, 0); lane(1, 1, 2, 30, 0, 0, 1, 0); lane(2, 1, 3, 45, 0, 0, 1, 0); go();
        // R8 younger candidate ignored
        idle_lanes(); cb = 1; lane(0, 1, 1, 50, 0, 0, 1, 0); go();
        // R8 older candidate replaces
        idle_lanes(); cb = 1; lane(0, 1, 1, 20, 0, 0, 1, 0); go();
        // R9 handled set, then clear
        idle_lanes(); hs = 1; go();
        idle_lanes(); clr = 1; go();
        idle_lanes(); go();
        // R9 clear and new younger record together: record wins
        idle_lanes(); cb = 1; lane(0, 1, 1, 60, 0, 0, 1, 0); go();
        idle_lanes(); clr = 1; cb = 1; lane(0, 1, 1, 70, 0, 0, 1, 0); go();
        // R9 handled set together with an older record
        idle_lanes(); hs = 1; go();
        idle_lanes(); hs = 1; cb = 1; lane(1, 1, 1, 5, 0, 0, 1, 0); go();
        idle_lanes(); go();
        // mixed traffic
        for (int c = 0; c < 3000; c++) begin
            idle_lanes();
            head = $urandom_range(0, 3);
            cb = ($urandom_range(0, 7) == 0);
            clr = ($urandom_range(0, 5) == 0);
            hs = ($urandom_range(0, 5) == 0);
            for (int i = 0; i < N; i++)
                lane(i, $urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 200),
                     $urandom_range(0, 1), $urandom_range(0, 3) == 0,
                     $urandom_range(0, 4) != 0, $urandom_range(0, 1));
            go();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule